// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the command pins of a DDR2 device from reset until the device can take normal traffic. A single start pulse launches a fixed sequence of thirteen commands. The sequence begins with two NOPs, and the clock enable rises with the second one. A precharge-all follows. Next come the extended mode-register loads for EMR2, EMR3 and EMR1, in that order, after which the sequencer waits for the DLL to lock. It then issues a mode-register load with the DLL-reset bit set, a second precharge-all and two auto-refreshes. A mode-register load with DLL reset cleared follows. An EMR1 pair that first sets and then exits the OCD default closes the sequence.

The system supplies the four mode-register payloads on input ports. The sequencer places the DLL-reset bit and the OCD field into them and picks the bank address for each load. Every gap between commands is a cycle-count parameter. The two long power-up waits are derived from a clock-period parameter. After the last command, a flag rises and stays high until reset, and a periodic timer begins to raise single-cycle refresh requests.

Top module: `ddr2_init_seq`

## Requirements
- R1: While rst_ni is low, and after reset until start, the outputs are: cke_o low, command NOP, ba_o and addr_o zero, init_done_o low, ref_req_o low.
- R2: The command pins {cs_n_o, ras_n_o, cas_n_o, we_n_o} use these codes: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode-register load = 0000. Every cycle that does not carry a sequence command carries NOP with ba_o and addr_o zero.
- R3: The first NOP appears in the cycle after the start edge (offset 0). The second NOP follows T_MRD cycles later, and cke_o rises with it and never falls before reset. A precharge-all with addr_o[10]=1 follows ceil(T_LONG_PS/CLK_PERIOD_PS) cycles later. With the defaults these offsets are 0, 2 and 56.
- R4: After a second long wait, the sequencer issues EMR2 at ba_o=2, then EMR3 at ba_o=3, then EMR1 at ba_o=1 with addr_o[9:7]=000. These loads are T_MRD apart, at offsets 110, 112 and 114.
- R5: The next command comes T_DLL cycles after the EMR1 (offset 314). It is a mode-register load at ba_o=0 with addr_o[8]=1.
- R6: A precharge-all (addr_o[10]=1) follows after T_MRD (offset 316). Two auto-refreshes follow, the first after T_RP and the second after T_RFC (offsets 318 and 332), both with ba_o and addr_o zero.
- R7: T_RFC after the second refresh, the sequencer issues a mode-register load at ba_o=0 with addr_o[8]=0 (offset 346). EMR1 with addr_o[9:7]=111 follows (offset 348), then EMR1 with addr_o[9:7]=000 (offset 350), both at ba_o=1 and T_MRD apart.
- R8: Each load carries its payload port (mr_i, emr1_i, emr2_i, emr3_i) unchanged, apart from the inserted bit or field named in R5 and R7.
- R9: init_done_o rises one cycle after the last EMR1 (offset 351) and stays high until reset. While it is high, the command is NOP.
- R10: After init_done_o rises, ref_req_o pulses for one cycle every REF_INTERVAL cycles. The first pulse comes REF_INTERVAL cycles after the rise (offsets 651, 951 with REF_INTERVAL=300).
- R11: A start pulse while the sequence runs, or after init_done_o is high, changes no output.
- R12: Reset asserted mid-sequence returns all outputs at once to the R1 state. A later start runs the whole sequence again from offset 0 using the current payloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches the sequence from idle |
| mr_i | input | ADDR_W | Mode-register payload |
| emr1_i | input | ADDR_W | Extended mode register 1 payload |
| emr2_i | input | ADDR_W | Extended mode register 2 payload |
| emr3_i | input | ADDR_W | Extended mode register 3 payload |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete |
| ref_req_o | output | 1 | Periodic refresh request pulse |

## Verification
All outputs are registered. A command therefore appears in the cycle after the clock edge that sees start_i high, which is offset 0, or after the edge that ends the previous gap. Command k is due at the sum of the preceding gaps: 0, 2, 56, 110, 112, 114, 314, 316, 318, 332, 346, 348 and 350. init_done_o is due at 351 and refresh pulses at 651 and 951. The bench counts offsets from the start edge and samples on the falling edge within each offset. It compares the full command word, cke_o, init_done_o and ref_req_o in every cycle. Every cycle between commands is therefore checked as NOP.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } ddr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_A10,
    SRC_MR_DLLRST,
    SRC_MR_NORM,
    SRC_EMR2,
    SRC_EMR3,
    SRC_EMR1_OCD_EXIT,
    SRC_EMR1_OCD_DFLT
  } addr_src_e;

  typedef enum logic [2:0] {
    W_MRD,
    W_LONG,
    W_RP,
    W_RFC,
    W_DLL
  } wait_e;

  localparam int NUM_STEPS = 13;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef struct packed {
    ddr_cmd_e  cmd;
    logic [1:0] ba;
    addr_src_e src;
    wait_e     wt;
    logic      cke_on;
    logic      last;
  } step_t;

  function automatic step_t step_lut(input logic [STEP_W-1:0] idx);
    step_t s;
    s.cmd    = CMD_NOP;
    s.ba     = 2'b00;
    s.src    = SRC_ZERO;
    s.wt     = W_MRD;
    s.cke_on = 1'b0;
    s.last   = 1'b0;
    case (idx)
      4'd0: ;
      4'd1: begin s.cke_on = 1'b1; s.wt = W_LONG; end
      4'd2: begin s.cmd = CMD_PRE; s.src = SRC_A10; s.wt = W_LONG; end
      4'd3: begin s.cmd = CMD_MRS; s.ba = 2'b10; s.src = SRC_EMR2; end
      4'd4: begin s.cmd = CMD_MRS; s.ba = 2'b11; s.src = SRC_EMR3; end
      4'd5: begin s.cmd = CMD_MRS; s.ba = 2'b01; s.src = SRC_EMR1_OCD_EXIT; s.wt = W_DLL; end
      4'd6: begin s.cmd = CMD_MRS; s.src = SRC_MR_DLLRST; end
      4'd7: begin s.cmd = CMD_PRE; s.src = SRC_A10; s.wt = W_RP; end
      4'd8: begin s.cmd = CMD_REF; s.wt = W_RFC; end
      4'd9: begin s.cmd = CMD_REF; s.wt = W_RFC; end
      4'd10: begin s.cmd = CMD_MRS; s.src = SRC_MR_NORM; end
      4'd11: begin s.cmd = CMD_MRS; s.ba = 2'b01; s.src = SRC_EMR1_OCD_DFLT; end
      4'd12: begin s.cmd = CMD_MRS; s.ba = 2'b01; s.src = SRC_EMR1_OCD_EXIT; s.last = 1'b1; end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr2_init_step_decode.sv
module ddr2_init_step_decode
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3,
  parameter int CNT_W  = 8,
  parameter int T_MRD  = 2,
  parameter int T_LONG = 54,
  parameter int T_RP   = 2,
  parameter int T_RFC  = 14,
  parameter int T_DLL  = 200
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] mr_i,
  input  logic [ADDR_W-1:0] emr1_i,
  input  logic [ADDR_W-1:0] emr2_i,
  input  logic [ADDR_W-1:0] emr3_i,
  output ddr_cmd_e          cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  wait_o,
  output logic              cke_on_o,
  output logic              last_o
);

  localparam int DLL_RST_BIT = 8;
  localparam int OCD_LSB     = 7;
  localparam int A10_BIT     = 10;

  step_t s;

  always_comb begin
    s        = step_lut(step_i);
    cmd_o    = s.cmd;
    ba_o     = BA_W'(s.ba);
    cke_on_o = s.cke_on;
    last_o   = s.last;
  end

  always_comb begin
    addr_o = '0;
    case (s.src)
      SRC_A10:       addr_o[A10_BIT] = 1'b1;
      SRC_MR_DLLRST: begin addr_o = mr_i; addr_o[DLL_RST_BIT] = 1'b1; end
      SRC_MR_NORM:   begin addr_o = mr_i; addr_o[DLL_RST_BIT] = 1'b0; end
      SRC_EMR2:      addr_o = emr2_i;
      SRC_EMR3:      addr_o = emr3_i;
      SRC_EMR1_OCD_EXIT: begin addr_o = emr1_i; addr_o[OCD_LSB+:3] = 3'b000; end
      SRC_EMR1_OCD_DFLT: begin addr_o = emr1_i; addr_o[OCD_LSB+:3] = 3'b111; end
      default:       addr_o = '0;
    endcase
  end

  always_comb begin
    case (s.wt)
      W_LONG:  wait_o = CNT_W'(T_LONG);
      W_RP:    wait_o = CNT_W'(T_RP);
      W_RFC:   wait_o = CNT_W'(T_RFC);
      W_DLL:   wait_o = CNT_W'(T_DLL);
      default: wait_o = CNT_W'(T_MRD);
    endcase
  end

endmodule

// File: rtl/ddr2_init_gap_timer.sv
module ddr2_init_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  // next command is due at the edge where one cycle remains
  assign expire_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ddr2_init_refresh_timer.sv
module ddr2_init_refresh_timer #(
  parameter int REF_INTERVAL = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic req_o
);

  localparam int RW = $clog2(REF_INTERVAL + 1);
  localparam logic [RW-1:0] RELOAD = RW'(REF_INTERVAL - 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      req_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= RELOAD;
      req_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= RELOAD;
      req_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q - RW'(1);
      req_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 3,
  parameter int CLK_PERIOD_PS = 7500,
  parameter int T_LONG_PS     = 400000,
  parameter int T_MRD         = 2,
  parameter int T_RP          = 2,
  parameter int T_RFC         = 14,
  parameter int T_DLL         = 200,
  parameter int REF_INTERVAL  = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] mr_i,
  input  logic [ADDR_W-1:0] emr1_i,
  input  logic [ADDR_W-1:0] emr2_i,
  input  logic [ADDR_W-1:0] emr3_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              ref_req_o
);

  localparam int T_LONG = (T_LONG_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int M1 = (T_MRD > T_LONG) ? T_MRD : T_LONG;
  localparam int M2 = (T_RP  > M1)     ? T_RP  : M1;
  localparam int M3 = (T_RFC > M2)     ? T_RFC : M2;
  localparam int MAX_WAIT = (T_DLL > M3) ? T_DLL : M3;
  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q, nxt_idx;
  ddr_cmd_e          cmd_q, dec_cmd;
  logic [BA_W-1:0]   ba_q, dec_ba;
  logic [ADDR_W-1:0] addr_q, dec_addr;
  logic [CNT_W-1:0]  dec_wait;
  logic              dec_cke_on, dec_last;
  logic              gap_expire, issue;

  assign nxt_idx = (state_q == ST_IDLE) ? '0 : step_q + STEP_W'(1);
  assign issue   = ((state_q == ST_IDLE) && start_i) ||
                   ((state_q == ST_RUN) && gap_expire);

  ddr2_init_step_decode #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .T_MRD(T_MRD), .T_LONG(T_LONG), .T_RP(T_RP), .T_RFC(T_RFC), .T_DLL(T_DLL)
  ) u_dec (
    .step_i  (nxt_idx),
    .mr_i    (mr_i),
    .emr1_i  (emr1_i),
    .emr2_i  (emr2_i),
    .emr3_i  (emr3_i),
    .cmd_o   (dec_cmd),
    .ba_o    (dec_ba),
    .addr_o  (dec_addr),
    .wait_o  (dec_wait),
    .cke_on_o(dec_cke_on),
    .last_o  (dec_last)
  );

  ddr2_init_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (issue),
    .load_val_i(dec_wait),
    .expire_o  (gap_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      cmd_q       <= CMD_NOP;
      ba_q        <= '0;
      addr_q      <= '0;
      cke_o       <= 1'b0;
      init_done_o <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (issue) begin
        step_q <= nxt_idx;
        cmd_q  <= dec_cmd;
        ba_q   <= dec_ba;
        addr_q <= dec_addr;
        if (dec_cke_on) cke_o <= 1'b1;
      end
      case (state_q)
        ST_IDLE: if (issue) state_q <= ST_RUN;
        ST_RUN:  if (issue && dec_last) state_q <= ST_FIN;
        ST_FIN: begin
          init_done_o <= 1'b1;
          state_q     <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;

  ddr2_init_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (init_done_o),
    .req_o (ref_req_o)
  );

endmodule

// File: rtl/ddr2_init_seq_checker.sv
module ddr2_init_seq_checker #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic              cs_n_i,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic [BA_W-1:0]   ba_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              done_i,
  input logic              req_i
);

  logic [3:0] cmd;
  assign cmd = {cs_n_i, ras_n_i, cas_n_i, we_n_i};

  assert_nop_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  assert_cke_low_nop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |-> (cmd == 4'b0111));

  assert_cke_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(cke_i));

  assert_pre_a10_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0010) |-> addr_i[10]);

  assert_ref_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0001) |-> (addr_i == '0 && ba_i == '0));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cmd == 4'b0111));

  assert_req_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !req_i);

  assert_req_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> done_i);

endmodule

bind ddr2_init_seq ddr2_init_seq_checker #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cke_i  (cke_o),
  .cs_n_i (cs_n_o),
  .ras_n_i(ras_n_o),
  .cas_n_i(cas_n_o),
  .we_n_i (we_n_o),
  .ba_i   (ba_o),
  .addr_i (addr_o),
  .done_i (init_done_o),
  .req_i  (ref_req_o)
);

// File: tb/ddr2_init_seq_test.sv
`timescale 1ns/1ps
module ddr2_init_seq_test;

  localparam int AW = 13;
  localparam int BW = 3;
  localparam int DONE_AT = 351;
  localparam int REF_PER = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] mr, e1, e2, e3;
  logic cke, cs_n, ras_n, cas_n, we_n, done, req;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails = 0;

  // {offset, cmd, ba, addr source}
  localparam logic [25:0] EXP_TAB [13] = '{
    {16'd0,   4'h7, 3'd0, 3'd0},
    {16'd2,   4'h7, 3'd0, 3'd0},
    {16'd56,  4'h2, 3'd0, 3'd1},
    {16'd110, 4'h0, 3'd2, 3'd4},
    {16'd112, 4'h0, 3'd3, 3'd5},
    {16'd114, 4'h0, 3'd1, 3'd6},
    {16'd314, 4'h0, 3'd0, 3'd2},
    {16'd316, 4'h2, 3'd0, 3'd1},
    {16'd318, 4'h1, 3'd0, 3'd0},
    {16'd332, 4'h1, 3'd0, 3'd0},
    {16'd346, 4'h0, 3'd0, 3'd3},
    {16'd348, 4'h0, 3'd1, 3'd7},
    {16'd350, 4'h0, 3'd1, 3'd6}
  };

  ddr2_init_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mr_i(mr), .emr1_i(e1), .emr2_i(e2), .emr3_i(e3),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .init_done_o(done), .ref_req_o(req)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [2:0] sel);
    logic [AW-1:0] a;
    case (sel)
      3'd1: begin a = '0; a[10] = 1'b1; end
      3'd2: begin a = mr; a[8] = 1'b1; end
      3'd3: begin a = mr; a[8] = 1'b0; end
      3'd4: a = e2;
      3'd5: a = e3;
      3'd6: begin a = e1; a[9:7] = 3'b000; end
      3'd7: begin a = e1; a[9:7] = 3'b111; end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic string req_of(input int i);
    if (i <= 2) return "R3";
    if (i <= 4) return "R4 R8";
    if (i == 5) return "R4 R8";
    if (i == 6) return "R5 R8";
    if (i <= 9) return "R6";
    return "R7 R8";
  endfunction

  task automatic check_reset_state(input string tag);
    chk(cke == 1'b0, tag, "cke", 32'(cke), 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'h7, tag, "cmd", 32'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(ba == '0 && addr == '0, tag, "ba/addr", 32'({ba, addr}), 0);
    chk(done == 1'b0 && req == 1'b0, tag, "done/req", 32'({done, req}), 0);
  endtask

  // k counts cycles after the start edge; outputs sampled at negedge
  task automatic run_seq(input int ncyc, input int poke_a, input int poke_b);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      start = (k == poke_a || k == poke_b) ? 1'b1 : 1'b0;
      begin
        int idx;
        logic [3:0] e_cmd;
        logic [BW-1:0] e_ba;
        logic [AW-1:0] e_addr;
        string tag;
        bit e_cke, e_done, e_req;
        idx = -1;
        for (int i = 0; i < 13; i++)
          if (int'(EXP_TAB[i][25:10]) == k) idx = i;
        if (idx >= 0) begin
          e_cmd  = EXP_TAB[idx][9:6];
          e_ba   = EXP_TAB[idx][5:3];
          e_addr = exp_addr(EXP_TAB[idx][2:0]);
          tag    = req_of(idx);
        end else begin
          e_cmd  = 4'h7;
          e_ba   = '0;
          e_addr = '0;
          tag    = "R2";
        end
        if (k == poke_a + 2 || k == poke_b + 2) tag = {tag, " R11"};
        chk({cs_n, ras_n, cas_n, we_n, ba, addr} == {e_cmd, e_ba, e_addr}, tag,
            $sformatf("cmd/ba/addr k=%0d", k),
            32'({cs_n, ras_n, cas_n, we_n, ba, addr}), 32'({e_cmd, e_ba, e_addr}));
        e_cke = (k >= 2);
        chk(cke == e_cke, "R3", $sformatf("cke k=%0d", k), 32'(cke), 32'(e_cke));
        e_done = (k >= DONE_AT);
        chk(done == e_done, "R9", $sformatf("init_done k=%0d", k), 32'(done), 32'(e_done));
        e_req = (k >= DONE_AT + REF_PER) && ((k - DONE_AT) % REF_PER == 0);
        chk(req == e_req, "R10", $sformatf("ref_req k=%0d", k), 32'(req), 32'(e_req));
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    mr = 13'h0a53; e1 = 13'h1c46; e2 = 13'h0080; e3 = 13'h1fff;
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("R1");

    // full run, start poked mid-sequence and after done (R11)
    run_seq(1000, 20, 400);

    // abort mid-sequence (R12)
    @(negedge clk) rst_n = 1'b0;
    #1 check_reset_state("R12");
    @(negedge clk) rst_n = 1'b1;
    mr = 13'h1555; e1 = 13'h0aaa; e2 = 13'h0001; e3 = 13'h0000;
    run_seq(120, -10, -10);
    @(negedge clk) rst_n = 1'b0;
    #1 check_reset_state("R12");
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_reset_state("R12");

    // restart with fresh payloads
    mr = 13'h0e31; e1 = 13'h0384; e2 = 13'h1234; e3 = 13'h0f0f;
    run_seq(360, -10, -10);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule